// File: doc/BRIEF.md
# Per-Slot Control Bit Serializer

This block drives one serial control line that runs beside a group of time-division data output streams. A frame is divided into channel time slots, and each slot is divided into bit times. During every slot the line carries one bit per output stream. Each bit is that stream's per-channel control flag, and all the bits in a slot belong to a single channel number. The stream 0 flag goes first and the highest stream goes last, so external circuitry can demultiplex the line with a bit counter.

The group for a channel is sent one slot before that channel's data appears on the streams. This gives slow external drivers or switches time to settle. Because of this lead, the group for channel 0 is sent in the last slot of the previous frame. The block reads the flags from the control memory itself, through a simple read port. It asks for a channel two slots before that channel's group goes out and latches the returned group at the end of the slot. A frame pulse aligns its slot counter.

Top module: `slot_ctl_serializer`

## Requirements
- R1: After reset, `ctl_out` is 0 until `frame_sync` has been sampled high twice. It is first valid in the cycle after the second pulse, which is slot 0 bit 0 of the first frame that is fully timed.
- R2: The cycle after `frame_sync` is sampled high is slot 0, bit 0. A slot lasts STREAMS (8) cycles and a frame has SLOTS (32) slots, so a frame is 256 cycles and `fetch_en` pulses 32 times in it.
- R3: In bit b of slot s, `ctl_out` equals bit b of the group held for channel (s+1) mod SLOTS. Bit b is the flag of stream b, so stream 0 goes out first and stream 7 last.
- R4: Slot 31, the last slot, carries the group for channel 0, which wraps into the next frame.
- R5: `fetch_en` is high for exactly one cycle per slot, at bit 6 (STREAMS-1-RD_LAT). In that cycle `fetch_chan` equals (s+3) mod SLOTS.
- R6: The group is taken from `fetch_bits` at the end of bit 7 of slot s-2. A change to the memory contents after that read does not change what slot s sends; the next frame sends the new value.
- R7: `fetch_bits` is ignored in every cycle except the one RD_LAT cycles after `fetch_en`. Non-zero values at other times never reach `ctl_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit-time clock, one bit per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_sync | input | 1 | High in the final bit time of a frame |
| fetch_en | output | 1 | Read strobe to the control memory |
| fetch_chan | output | 5 | Channel number to read |
| fetch_bits | input | 8 | Per-stream flags of the requested channel, returned RD_LAT cycles after the strobe |
| ctl_out | output | 1 | Serial control line |

## Verification
A wrong slot or bit counter moves `fetch_en` off bit 6 or makes `fetch_chan` differ from slot+3 in the same slot, so it shows within 8 cycles. A fault in the latch or shifter path gives a wrong bit on `ctl_out` in the slot that carries the damaged group, which is two slots after the read. A wrong arming state either leaks ones during the first frame or leaves the line silent at the start of the second frame. The bench therefore fills every channel with patterns whose bits differ per stream and compares whole frames, including the slot that wraps to channel 0.

// File: rtl/ctlser_pkg.sv
package ctlser_pkg;

   // Arming progress after reset: no pulse yet, one pulse seen, output live.
   typedef enum logic [1:0] {
      ARM_IDLE  = 2'd0,
      ARM_FIRST = 2'd1,
      ARM_LIVE  = 2'd2
   } arm_state_e;

   // Slots between the slot that sends a group and the slot whose data it controls.
   localparam int unsigned SEND_LEAD = 1;
   // Slots between reading a group and sending it.
   localparam int unsigned READ_AHEAD = 2;

endpackage

// File: rtl/ctlser_timer.sv
module ctlser_timer
   import ctlser_pkg::*;
#(
   parameter int unsigned SLOTS   = 32,
   parameter int unsigned STREAMS = 8,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned BW = $clog2(STREAMS)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          frame_sync,
   output logic [SW-1:0] slot_q,
   output logic [BW-1:0] bit_q,
   output logic          next_is_bit0,
   output logic          live
);

   localparam logic [BW-1:0] LAST_BIT  = BW'(STREAMS - 1);
   localparam logic [SW-1:0] LAST_SLOT = SW'(SLOTS - 1);

   arm_state_e arm_q;

   assign next_is_bit0 = frame_sync || (bit_q == LAST_BIT);
   assign live         = (arm_q == ARM_LIVE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else if (frame_sync) begin
         slot_q <= '0;
         bit_q  <= '0;
      end else if (bit_q == LAST_BIT) begin
         bit_q  <= '0;
         slot_q <= (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
      end else begin
         bit_q  <= bit_q + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         arm_q <= ARM_IDLE;
      end else if (frame_sync) begin
         case (arm_q)
            ARM_IDLE:  arm_q <= ARM_FIRST;
            default:   arm_q <= ARM_LIVE;
         endcase
      end
   end

endmodule

// File: rtl/ctlser_fetch.sv
module ctlser_fetch
   import ctlser_pkg::*;
#(
   parameter int unsigned SLOTS   = 32,
   parameter int unsigned STREAMS = 8,
   parameter int unsigned RD_LAT  = 1,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned BW = $clog2(STREAMS)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SW-1:0]      slot_q,
   input  logic [BW-1:0]      bit_q,
   output logic               fetch_en,
   output logic [SW-1:0]      fetch_chan,
   input  logic [STREAMS-1:0] fetch_bits,
   output logic [STREAMS-1:0] hold_q
);

   localparam int unsigned   AHEAD    = SEND_LEAD + READ_AHEAD;
   localparam logic [BW-1:0] REQ_BIT  = BW'(STREAMS - 1 - RD_LAT);
   localparam logic [BW-1:0] TAKE_BIT = BW'(STREAMS - 1);

   assign fetch_en = (bit_q == REQ_BIT);

   generate
      if ((SLOTS & (SLOTS - 1)) == 0) begin : g_pow2_wrap
         assign fetch_chan = slot_q + SW'(AHEAD);
      end else begin : g_cmp_wrap
         logic [SW:0] sum;
         assign sum        = {1'b0, slot_q} + (SW + 1)'(AHEAD);
         assign fetch_chan = (sum >= (SW + 1)'(SLOTS)) ?
                             SW'(sum - (SW + 1)'(SLOTS)) : SW'(sum);
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q <= '0;
      end else if (bit_q == TAKE_BIT) begin
         hold_q <= fetch_bits;
      end
   end

endmodule

// File: rtl/ctlser_shift.sv
module ctlser_shift #(
   parameter int unsigned STREAMS = 8
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [STREAMS-1:0] hold_q,
   input  logic               live,
   output logic               ctl_out
);

   logic [STREAMS-1:0] sh_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q <= '0;
      end else if (load) begin
         sh_q <= hold_q;
      end else begin
         sh_q <= {1'b0, sh_q[STREAMS-1:1]};
      end
   end

   assign ctl_out = live & sh_q[0];

endmodule

// File: rtl/slot_ctl_serializer.sv
module slot_ctl_serializer #(
   parameter int unsigned SLOTS   = 32,
   parameter int unsigned STREAMS = 8,
   parameter int unsigned RD_LAT  = 1,
   localparam int unsigned SW = $clog2(SLOTS),
   localparam int unsigned BW = $clog2(STREAMS)
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               frame_sync,
   output logic               fetch_en,
   output logic [SW-1:0]      fetch_chan,
   input  logic [STREAMS-1:0] fetch_bits,
   output logic               ctl_out
);

   generate
      if (STREAMS < 2 || SLOTS < 4) begin : g_bad_size
         initial $fatal(1, "slot_ctl_serializer: STREAMS>=2 and SLOTS>=4 required");
      end
      if (RD_LAT < 1 || RD_LAT > STREAMS - 1) begin : g_bad_lat
         initial $fatal(1, "slot_ctl_serializer: RD_LAT must lie in 1..STREAMS-1");
      end
   endgenerate

   logic [SW-1:0]      slot_q;
   logic [BW-1:0]      bit_q;
   logic               next_is_bit0;
   logic               live;
   logic [STREAMS-1:0] hold_q;

   ctlser_timer #(.SLOTS(SLOTS), .STREAMS(STREAMS)) u_timer (
      .clk          (clk),
      .rst_n        (rst_n),
      .frame_sync   (frame_sync),
      .slot_q       (slot_q),
      .bit_q        (bit_q),
      .next_is_bit0 (next_is_bit0),
      .live         (live)
   );

   ctlser_fetch #(.SLOTS(SLOTS), .STREAMS(STREAMS), .RD_LAT(RD_LAT)) u_fetch (
      .clk        (clk),
      .rst_n      (rst_n),
      .slot_q     (slot_q),
      .bit_q      (bit_q),
      .fetch_en   (fetch_en),
      .fetch_chan (fetch_chan),
      .fetch_bits (fetch_bits),
      .hold_q     (hold_q)
   );

   ctlser_shift #(.STREAMS(STREAMS)) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (next_is_bit0),
      .hold_q  (hold_q),
      .live    (live),
      .ctl_out (ctl_out)
   );

endmodule

// File: rtl/slot_ctl_serializer_chk.sv
module slot_ctl_serializer_chk #(
   parameter int unsigned SLOTS   = 32,
   parameter int unsigned STREAMS = 8,
   parameter int unsigned RD_LAT  = 1,
   localparam int unsigned SW = $clog2(SLOTS)
)(
   input logic               clk,
   input logic               rst_n,
   input logic               frame_sync,
   input logic               fetch_en,
   input logic [SW-1:0]      fetch_chan,
   input logic [STREAMS-1:0] fetch_bits,
   input logic               ctl_out
);

   int unsigned        c_slot, c_bit;
   logic [1:0]         c_syncs;
   logic [STREAMS-1:0] grp [SLOTS];
   logic               c_seen, c_live, exp_bit;
   logic [SW-1:0]      exp_chan;

   assign c_seen   = (c_syncs != 2'd0);
   assign c_live   = (c_syncs == 2'd2);
   assign exp_bit  = grp[(c_slot + 1) % SLOTS][c_bit];
   assign exp_chan = SW'((c_slot + 3) % SLOTS);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         c_slot  <= 0;
         c_bit   <= 0;
         c_syncs <= 2'd0;
         for (int i = 0; i < SLOTS; i++) grp[i] <= '0;
      end else begin
         if (frame_sync) begin
            c_slot <= 0;
            c_bit  <= 0;
            if (c_syncs != 2'd2) c_syncs <= c_syncs + 2'd1;
         end else if (c_bit == STREAMS - 1) begin
            c_bit  <= 0;
            c_slot <= (c_slot + 1) % SLOTS;
         end else begin
            c_bit <= c_bit + 1;
         end
         if (c_seen && c_bit == STREAMS - 1)
            grp[(c_slot + 3) % SLOTS] <= fetch_bits;
      end
   end

   // R1
   quiet_until_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !c_live |-> !ctl_out);

   // R2
   fetch_position_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_seen |-> (fetch_en == (c_bit == STREAMS - 1 - RD_LAT)));

   // R5
   fetch_channel_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (c_seen && fetch_en) |-> (fetch_chan == exp_chan));

   // R5
   fetch_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fetch_en |=> !fetch_en);

   // R3
   group_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      c_live |-> (ctl_out == exp_bit));

endmodule

bind slot_ctl_serializer slot_ctl_serializer_chk #(
   .SLOTS(SLOTS), .STREAMS(STREAMS), .RD_LAT(RD_LAT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .frame_sync (frame_sync),
   .fetch_en   (fetch_en),
   .fetch_chan (fetch_chan),
   .fetch_bits (fetch_bits),
   .ctl_out    (ctl_out)
);

// File: tb/tb_slot_ctl_serializer.sv
module tb_slot_ctl_serializer;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       frame_sync;
   logic       fetch_en;
   logic [4:0] fetch_chan;
   logic [7:0] fetch_bits;
   logic       ctl_out;

   always #2 clk = ~clk;

   slot_ctl_serializer dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_sync (frame_sync),
      .fetch_en   (fetch_en),
      .fetch_chan (fetch_chan),
      .fetch_bits (fetch_bits),
      .ctl_out    (ctl_out)
   );

   // Control memory model: one cycle read latency, noise when not read.
   logic [7:0] mem [32];
   logic [7:0] lfsr = 8'hB7;
   always @(posedge clk) begin
      lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      fetch_bits <= fetch_en ? mem[fetch_chan] : lfsr;
   end

   int  n_checks = 0;
   int  n_fail   = 0;
   int  cyc      = 0;
   bit  gen_on   = 0;
   int  bpos     = 255;
   int  sync_cnt = 0;
   int  s_pos;
   logic s_ctl, s_fen;
   logic [4:0] s_fch;

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
   endtask

   always @(posedge clk) begin
      cyc <= cyc + 1;
      if (cyc > 150000) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog R2 actual=%0d expected=%0d", cyc, 150000);
         summary();
         $finish;
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // Sample outputs for position s_pos, then drive frame_sync for this cycle.
   task automatic step();
      @(negedge clk);
      s_ctl = ctl_out;
      s_fen = fetch_en;
      s_fch = fetch_chan;
      s_pos = bpos;
      if (gen_on) begin
         frame_sync = (bpos == 255);
         if (bpos == 255) sync_cnt++;
         bpos = (bpos + 1) % 256;
      end else begin
         frame_sync = 1'b0;
      end
   endtask

   task automatic run_to(input int tgt);
      do step(); while (s_pos != tgt);
   endtask

   task automatic grab_group(output logic [7:0] g);
      g[0] = s_ctl;
      for (int b = 1; b < 8; b++) begin
         step();
         g[b] = s_ctl;
      end
   endtask

   // R1: zero until the second pulse after release, then valid at once.
   task automatic arm_and_check(input string tag);
      int leaks = 0;
      logic [7:0] g;
      forever begin
         int c = sync_cnt;
         step();
         if (c >= 2) break;
         if (s_ctl !== 1'b0) leaks++;
      end
      check(leaks == 0, {tag, " R1 quiet before arming"}, leaks, 0);
      check(s_pos == 0, {tag, " R2 first live cycle is slot 0 bit 0"}, s_pos, 0);
      grab_group(g);
      check(g == mem[1], {tag, " R1 first live slot"}, g, mem[1]);
   endtask

   task automatic t_reset();
      int leaks = 0;
      for (int c = 0; c < 32; c++) mem[c] = 8'hFF;
      rst_n = 1'b0;
      frame_sync = 1'b0;
      repeat (4) step();
      check(ctl_out === 1'b0, "R1 during reset", ctl_out, 0);
      rst_n = 1'b1;
      for (int i = 0; i < 40; i++) begin
         step();
         if (s_ctl !== 1'b0) leaks++;
      end
      check(leaks == 0, "R1 no pulse yet", leaks, 0);
      bpos = 255;
      sync_cnt = 0;
      gen_on = 1;
      arm_and_check("reset");
   endtask

   task automatic t_pattern(input string name, input int kind);
      logic [7:0] g;
      for (int c = 0; c < 32; c++) begin
         case (kind)
            0: mem[c] = 8'(1 << (c % 8));
            1: mem[c] = (c % 2 == 0) ? 8'h55 : 8'hAA;
            2: mem[c] = 8'((c * 37 + 11) ^ (c << 3));
            default: mem[c] = 8'(c + 1);
         endcase
      end
      repeat (300) step();
      for (int s = 0; s < 32; s++) begin
         run_to(s * 8);
         grab_group(g);
         if (s == 31)
            check(g == mem[0], {name, " R4 slot 31 carries channel 0"}, g, mem[0]);
         else
            check(g == mem[s + 1], {name, " R3 slot group"}, g, mem[s + 1]);
      end
   endtask

   task automatic t_fetch();
      int bad_pos = 0, bad_chan = 0, pulses = 0;
      run_to(255);
      for (int i = 0; i < 256; i++) begin
         step();
         if (s_fen !== ((s_pos % 8) == 6)) bad_pos++;
         if (s_fen === 1'b1) begin
            pulses++;
            if (s_fch != 5'(((s_pos / 8) + 3) % 32)) bad_chan++;
         end
      end
      check(bad_pos == 0, "R5 strobe at bit 6", bad_pos, 0);
      check(bad_chan == 0, "R5 channel is slot+3", bad_chan, 0);
      check(pulses == 32, "R2 strobes per frame", pulses, 32);
   endtask

   task automatic t_late_write();
      logic [7:0] g;
      mem[10] = 8'hA5;
      repeat (300) step();
      run_to(64);          // slot 8: channel 10 was read in slot 7
      mem[10] = 8'h3C;
      run_to(72);
      grab_group(g);
      check(g == 8'hA5, "R6 late write not seen this frame", g, 8'hA5);
      run_to(72);
      grab_group(g);
      check(g == 8'h3C, "R6 late write seen next frame", g, 8'h3C);
   endtask

   task automatic t_noise();
      int ones = 0;
      for (int c = 0; c < 32; c++) mem[c] = 8'h00;
      repeat (300) step();
      for (int i = 0; i < 512; i++) begin
         step();
         if (s_ctl !== 1'b0) ones++;
      end
      check(ones == 0, "R7 noise on fetch_bits ignored", ones, 0);
   endtask

   task automatic t_rearm();
      for (int c = 0; c < 32; c++) mem[c] = 8'hFF;
      run_to(100);
      rst_n = 1'b0;
      repeat (3) step();
      run_to(120);
      rst_n = 1'b1;
      sync_cnt = 0;
      arm_and_check("rearm");
   endtask

   initial begin
      t_reset();
      t_pattern("walk", 0);
      t_pattern("alt", 1);
      t_pattern("mix", 2);
      t_pattern("count", 3);
      t_fetch();
      t_late_write();
      t_noise();
      t_rearm();
      summary();
      $finish;
   end

endmodule